// File: doc/BRIEF.md
# Half-Bridge Deadtime and Interlock Controller

This block is the clocked control core that sits in front of the two gate-drive stages of a half-bridge. It takes a high-side request `hin` and a low-side request `lin`, both active high. It also takes two undervoltage flags: `uv_ls` for the low-side supply and `uv_hs` for the floating high-side supply. From these it produces the two gate enables `ho` and `lo`. Every input first passes a two-flop synchronizer and then a persistence filter, so a short glitch on a request or a brief dip on a supply flag never reaches the gate logic.

After filtering, a deadtime stage holds each output off until the opposite output has been low for a fixed number of cycles. The same stage keeps both outputs from being on together. An undervoltage on either supply drives both outputs off. The two sides then recover in different ways: the low side follows its request level again as soon as the supply is good, but the high side waits for a new rising edge on its request. A build parameter removes the deadtime and the interlock, so that each output follows its own filtered request.

All time constants are given in nanoseconds. They are converted to cycles with a ceiling division by `CLK_PERIOD_NS`. With the defaults (20 ns clock, 75 ns filter, 75 ns deadtime, 1800 ns supply filter) this gives 4, 4 and 90 cycles.

Top module: `hb_gate_ctrl`

## Requirements
- R1: A request pulse on `hin` or `lin` shorter than FILT_CYC cycles (4 at defaults) never appears on `ho` or `lo`. A level held for FILT_CYC cycles or more does reach the output.
- R2: With deadtime enabled, an output rises only after the opposite output has been low for at least DEAD_CYC consecutive cycles (4 at defaults).
- R3: With interlock enabled, `ho` and `lo` are never high in the same cycle. While both filtered requests are high, both outputs are low.
- R4: With `DT_ILK_EN` = 0, each output follows its own filtered request with no added gap. Both outputs may be high together.
- R5: While either filtered undervoltage flag is set, both `ho` and `lo` are low from the next cycle on.
- R6: An undervoltage flag pulse shorter than UV_CYC cycles (90 at defaults) causes no lockout.
- R7: When the low-side supply recovers, `lo` takes the current `lin` level without needing a new edge.
- R8: After the high-side supply recovers, `ho` stays low while `hin` is held high. It rises only after a new rising edge of the filtered `hin`.
- R9: Synchronous reset drives both outputs low and clears the high-side arm. A `hin` held high through reset does not turn `ho` on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous reset, active high |
| hin | input | 1 | High-side gate request, active high, asynchronous |
| lin | input | 1 | Low-side gate request, active high, asynchronous |
| uv_ls | input | 1 | Low-side supply undervoltage flag, active high, asynchronous |
| uv_hs | input | 1 | High-side supply undervoltage flag, active high, asynchronous |
| ho | output | 1 | High-side gate enable |
| lo | output | 1 | Low-side gate enable |

## Verification
The assertions assume the asynchronous inputs are sampled cleanly by the synchronizers. They also assume reset is held long enough to load the supply filters with their locked-out value. The bench meets both conditions: it changes inputs only on falling clock edges and holds reset for several cycles. Apart from the deliberate glitches, the bench holds every request level for at least five times the filter length. It holds undervoltage flags well beyond UV_CYC, so each check samples settled outputs. The bench measures the deadtime gap by counting cycles at the ports, not at fixed offsets.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Ceiling conversion of a time in ns to clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/hbg_persist_filter.sv
// Synchronizes an asynchronous level and updates the output only after the
// synchronized value has differed from it for CYC consecutive cycles.
module hbg_persist_filter #(
  parameter int CYC      = 4,
  parameter bit RST_VAL  = 1'b0,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       run_q;
  logic                out_q;
  logic                s_val;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_LEN{RST_VAL}};
    else     sync_q <= {sync_q[SYNC_LEN-2:0], din};
  end

  assign s_val = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= RST_VAL;
      run_q <= '0;
    end else if (s_val == out_q) begin
      run_q <= '0;
    end else if (run_q == CW'(CYC - 1)) begin
      out_q <= s_val;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/hbg_rearm.sv
// High-side arm flag: cleared by reset or high-side lockout, set by a
// rising edge of the filtered request outside lockout.
module hbg_rearm (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic lock,
  output logic armed
);
  logic req_q;
  logic arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      req_q <= req;
      if (lock)              arm_q <= 1'b0;
      else if (req && !req_q) arm_q <= 1'b1;
    end
  end

  assign armed = arm_q;
endmodule

// File: rtl/hbg_deadtime.sv
// Output stage: deadtime insertion and cross interlock, or a plain register
// pair when EN is 0.
module hbg_deadtime
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter bit EN       = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  gate_pair_t req,
  output gate_pair_t gate
);
  gate_pair_t gate_q;

  generate
    if (EN) begin : g_guard
      localparam int CW = $clog2(DEAD_CYC + 1);
      logic [CW-1:0] lo_idle_q, hi_idle_q;
      logic          both;
      gate_pair_t    nxt;

      always_ff @(posedge clk) begin
        if (rst) begin
          lo_idle_q <= CW'(DEAD_CYC);
          hi_idle_q <= CW'(DEAD_CYC);
        end else begin
          if (gate_q.lo)                         lo_idle_q <= '0;
          else if (lo_idle_q != CW'(DEAD_CYC))   lo_idle_q <= lo_idle_q + 1'b1;
          if (gate_q.hi)                         hi_idle_q <= '0;
          else if (hi_idle_q != CW'(DEAD_CYC))   hi_idle_q <= hi_idle_q + 1'b1;
        end
      end

      always_comb begin
        both   = req.hi && req.lo;
        nxt.hi = req.hi && !both && !gate_q.lo && (lo_idle_q == CW'(DEAD_CYC));
        nxt.lo = req.lo && !both && !gate_q.hi && (hi_idle_q == CW'(DEAD_CYC));
      end

      always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= nxt;
      end
    end else begin : g_raw
      always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= req;
      end
    end
  endgenerate

  assign gate = gate_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int FILT_NS       = 75,
  parameter int DEAD_NS       = 75,
  parameter int UV_FILT_NS    = 1800,
  parameter bit DT_ILK_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hin,
  input  logic lin,
  input  logic uv_ls,
  input  logic uv_hs,
  output logic ho,
  output logic lo
);
  localparam int FILT_CYC = ns_to_cyc(FILT_NS, CLK_PERIOD_NS);
  localparam int DEAD_CYC = ns_to_cyc(DEAD_NS, CLK_PERIOD_NS);
  localparam int UV_CYC   = ns_to_cyc(UV_FILT_NS, CLK_PERIOD_NS);

  logic       fh, fl;
  logic       uv_ls_f, uv_hs_f, uv_any;
  logic       hs_armed;
  gate_pair_t req, gate;

  hbg_persist_filter #(.CYC(FILT_CYC), .RST_VAL(1'b0)) u_f_hin (
    .clk(clk), .rst(rst), .din(hin), .dout(fh));
  hbg_persist_filter #(.CYC(FILT_CYC), .RST_VAL(1'b0)) u_f_lin (
    .clk(clk), .rst(rst), .din(lin), .dout(fl));
  hbg_persist_filter #(.CYC(UV_CYC), .RST_VAL(1'b1)) u_f_uvl (
    .clk(clk), .rst(rst), .din(uv_ls), .dout(uv_ls_f));
  hbg_persist_filter #(.CYC(UV_CYC), .RST_VAL(1'b1)) u_f_uvh (
    .clk(clk), .rst(rst), .din(uv_hs), .dout(uv_hs_f));

  assign uv_any = uv_ls_f || uv_hs_f;

  hbg_rearm u_rearm (
    .clk(clk), .rst(rst), .req(fh), .lock(uv_hs_f), .armed(hs_armed));

  always_comb begin
    req.hi = fh && hs_armed && !uv_any;
    req.lo = fl && !uv_any;
  end

  hbg_deadtime #(.DEAD_CYC(DEAD_CYC), .EN(DT_ILK_EN)) u_dt (
    .clk(clk), .rst(rst), .req(req), .gate(gate));

  assign ho = gate.hi;
  assign lo = gate.lo;
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DEAD_CYC  = 4,
  parameter bit DT_ILK_EN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ho,
  input logic lo,
  input logic uv_any,
  input logic hs_armed
);
  int lo_quiet, ho_quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_quiet <= DEAD_CYC + 1;
      ho_quiet <= DEAD_CYC + 1;
    end else begin
      lo_quiet <= lo ? 0 : ((lo_quiet > DEAD_CYC) ? lo_quiet : lo_quiet + 1);
      ho_quiet <= ho ? 0 : ((ho_quiet > DEAD_CYC) ? ho_quiet : ho_quiet + 1);
    end
  end

  generate
    if (DT_ILK_EN) begin : g_guard_chk
      // R3
      no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(ho && lo));
      // R2
      hi_deadtime_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ho) |-> (lo_quiet >= DEAD_CYC));
      // R2
      lo_deadtime_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lo) |-> (ho_quiet >= DEAD_CYC));
    end
  endgenerate

  // R5
  uv_force_off_chk: assert property (@(posedge clk) disable iff (rst)
    uv_any |=> (!ho && !lo));

  // R8
  hi_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ho) |-> $past(hs_armed));
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .DEAD_CYC(DEAD_CYC),
  .DT_ILK_EN(DT_ILK_EN)
) chk_i (
  .clk(clk),
  .rst(rst),
  .ho(ho),
  .lo(lo),
  .uv_any(uv_any),
  .hs_armed(hs_armed)
);

// File: tb/hb_gate_ctrl_tb_top.sv
module hb_gate_ctrl_tb_top;
  localparam int DEAD_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hin = 1'b0, lin = 1'b0, uv_ls = 1'b0, uv_hs = 1'b0;
  logic ho, lo, ho_r, lo_r;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  hb_gate_ctrl dut_i (
    .clk(clk), .rst(rst), .hin(hin), .lin(lin),
    .uv_ls(uv_ls), .uv_hs(uv_hs), .ho(ho), .lo(lo));

  hb_gate_ctrl #(.DT_ILK_EN(1'b0)) dut_raw_i (
    .clk(clk), .rst(rst), .hin(hin), .lin(lin),
    .uv_ls(uv_ls), .uv_hs(uv_hs), .ho(ho_r), .lo(lo_r));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    hin = 1'b1;
    rst = 1'b1;
    wait_cyc(5);
    check("R9 ho low in reset", ho, 0);
    check("R9 lo low in reset", lo, 0);
    rst = 1'b0;
    wait_cyc(130);
    check("R9 ho stays low with hin held through reset", ho, 0);
    hin = 1'b0;
    wait_cyc(20);
    hin = 1'b1;
    wait_cyc(20);
    check("R8 ho on after new hin edge", ho, 1);
    hin = 1'b0;
    wait_cyc(20);
  endtask

  task automatic t_glitch;
    int seen;
    seen = 0;
    hin = 1'b1;
    wait_cyc(3);
    hin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ho) seen++;
    end
    check("R1 3-cycle hin pulse blocked", seen, 0);
    seen = 0;
    lin = 1'b1;
    wait_cyc(2);
    lin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lo) seen++;
    end
    check("R1 2-cycle lin pulse blocked", seen, 0);
    seen = 0;
    lin = 1'b1;
    wait_cyc(6);
    lin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lo) seen++;
    end
    check("R1 6-cycle lin pulse passed", (seen > 0) ? 1 : 0, 1);
    wait_cyc(10);
  endtask

  task automatic t_deadtime;
    int gap, gap_r;
    bit fell, fell_r, rose, rose_r;
    lin = 1'b1;
    hin = 1'b0;
    wait_cyc(20);
    check("R7 lo follows lin", lo, 1);
    gap = 0; gap_r = 0;
    fell = 0; fell_r = 0; rose = 0; rose_r = 0;
    lin = 1'b0;
    hin = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!lo) fell = 1;
      if (ho) rose = 1;
      if (fell && !rose) gap++;
      if (!lo_r) fell_r = 1;
      if (ho_r) rose_r = 1;
      if (fell_r && !rose_r) gap_r++;
    end
    check("R2 ho reached on after lo off", ho, 1);
    check("R2 deadtime gap at least DEAD_CYC", (gap >= DEAD_CYC) ? 1 : 0, 1);
    check("R4 no gap without deadtime", gap_r, 0);
    hin = 1'b0;
    wait_cyc(20);
  endtask

  task automatic t_interlock;
    hin = 1'b1;
    lin = 1'b1;
    wait_cyc(25);
    check("R3 ho off with both requests", ho, 0);
    check("R3 lo off with both requests", lo, 0);
    check("R4 raw ho on with both requests", ho_r, 1);
    check("R4 raw lo on with both requests", lo_r, 1);
    hin = 1'b0;
    lin = 1'b0;
    wait_cyc(20);
  endtask

  task automatic t_uv_low;
    lin = 1'b1;
    wait_cyc(20);
    uv_ls = 1'b1;
    wait_cyc(150);
    check("R5 lo off in low-side UV", lo, 0);
    check("R5 raw lo off in low-side UV", lo_r, 0);
    uv_ls = 1'b0;
    wait_cyc(130);
    check("R7 lo resumes lin level after recovery", lo, 1);
    lin = 1'b0;
    wait_cyc(20);
  endtask

  task automatic t_uv_high;
    int drop;
    hin = 1'b1;
    wait_cyc(20);
    check("R8 ho on before lockout", ho, 1);
    drop = 0;
    uv_hs = 1'b1;
    wait_cyc(30);
    uv_hs = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!ho) drop++;
    end
    check("R6 short uv_hs pulse ignored", drop, 0);
    uv_hs = 1'b1;
    lin = 1'b1;
    wait_cyc(150);
    check("R5 ho off in high-side UV", ho, 0);
    check("R5 lo off in high-side UV", lo, 0);
    lin = 1'b0;
    wait_cyc(10);
    uv_hs = 1'b0;
    wait_cyc(130);
    check("R8 ho held off with hin high after recovery", ho, 0);
    hin = 1'b0;
    wait_cyc(20);
    hin = 1'b1;
    wait_cyc(20);
    check("R8 ho on after fresh edge", ho, 1);
    hin = 1'b0;
    wait_cyc(20);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_deadtime();
    t_interlock();
    t_uv_low();
    t_uv_high();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule